// File: doc/BRIEF.md
# Double-Buffered Grayscale PWM Generator with Staggered Outputs

This block turns sixteen per-channel 16-bit brightness levels into sixteen on/off enables for constant-current output stages. A free-running count, advanced on every edge of the grayscale clock, runs through a period of 4096 steps (narrow mode) or 65536 steps (wide mode). A channel is enabled while the count is below its active level, so the share of the period for which it is on equals the level.

Levels arrive on a valid/ready write stream that fills a bank of holding registers, one per channel. Nothing written there reaches the outputs until a global transfer is requested. The request is held until the end of the current period, then all sixteen active levels are replaced in the same cycle, so every PWM period is produced entirely from one set of levels. The write stream never applies back-pressure once reset is released: `wr_ready` is high whenever `rst_n` is high, and a write is taken on every edge where both `wr_valid` and `wr_ready` are high.

To spread the switching current, the outputs form groups of four (channel 4n+k with k = 0..3). With staggering switched on, member k of each group is delayed by k grayscale clock cycles relative to member 0; with it off, all sixteen outputs switch together.

Top module: `gsp_pwm_top`

## Requirements
- R1: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high; it stores `wr_level` into the holding register of channel `wr_chan` (0..15) and changes no output until a later transfer. `wr_ready` equals `rst_n`.
- R2: A pulse on `latch_all` arms a transfer. At the edge where the count wraps to zero, an armed transfer copies all sixteen holding registers into the active levels together and disarms. Active levels change at no other time, and a write accepted after the pulse but before the wrap is included in the transfer.
- R3: The count rises by one per clock. With `wide_mode`=0 it returns to 0 after a count whose low 12 bits are all ones; with `wide_mode`=1 it returns to 0 after 65535.
- R4: Channel i is on while count < level_i. With `wide_mode`=0 only the low 12 bits of the count and of the level are compared, so over any 4096 consecutive cycles a channel is on for exactly (level & 0xFFF) cycles; with `wide_mode`=1 it is on for exactly level cycles out of any 65536.
- R5: A channel whose compared level is 0 is never on.
- R6: With `stagger_en`=1, output 4n+k equals the undelayed result of that channel from k cycles earlier (k = 0..3); with `stagger_en`=0 every output shows its undelayed result.
- R7: Reset (`rst_n`=0, synchronous) clears the count, the holding registers, the active levels, the pending transfer and the delay lines, so every output is 0.
- R8: The undelayed result of channel i appears on `ch_on[i]` one clock after the count and active level it was compared from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Level write request |
| wr_ready | output | 1 | Write accept; high whenever out of reset |
| wr_chan | input | 4 | Channel whose holding register is written |
| wr_level | input | 16 | Level value to store |
| latch_all | input | 1 | Arms a transfer of all holding registers at the next wrap |
| wide_mode | input | 1 | 0: 4096-step period, 1: 65536-step period |
| stagger_en | input | 1 | 1: delay group member k by k cycles |
| ch_on | output | 16 | Channel enables |

## Verification
The embedded assertions watch every cycle for the count's wrap points in both modes, writes landing in the addressed holding register, active levels changing only at the start of a period, zero levels producing no pulse, and each delayed output matching its undelayed result from exactly its lag earlier or matching it directly when staggering is off. What only the bench scenarios can show is the overall behaviour: that the on-time over a full period equals each level in both modes, that held writes without a transfer leave the outputs alone, that a write squeezed between the transfer request and the wrap is picked up, and that the four group members rise one cycle apart.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned GS_W     = 16;
  localparam int unsigned NARROW_W = 12;
  localparam int unsigned NCH      = 16;
  localparam int unsigned GRP      = 4;
  localparam int unsigned CH_W     = $clog2(NCH);
endpackage

// File: rtl/gsp_count.sv
module gsp_count #(
  parameter int unsigned W  = 16,
  parameter int unsigned NW = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wide,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = wide ? (&cnt_q) : (&cnt_q[NW-1:0]);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R3: narrow period ends after low bits all ones
  a_r3_narrow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && (&cnt_q[NW-1:0])) |=> (cnt_q == '0));
  // R3: wide period ends after the full count
  a_r3_wide_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && (&cnt_q)) |=> (cnt_q == '0));
  // R3: otherwise one step per clock
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cnt_q[NW-1:0])) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/gsp_level_bank.sv
module gsp_level_bank #(
  parameter int unsigned NCH = 16,
  parameter int unsigned W   = 16,
  parameter int unsigned NW  = 12,
  parameter int unsigned CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_fire,
  input  logic [CW-1:0]  wr_chan,
  input  logic [W-1:0]   wr_level,
  input  logic           latch_all,
  input  logic           wide,
  input  logic [W-1:0]   cnt,
  input  logic           wrap,
  output logic [NCH-1:0] raw_on
);
  logic [W-1:0]   hold_q [NCH];
  logic [W-1:0]   act_q  [NCH];
  logic           pend_q;
  logic           xfer;
  logic [NCH-1:0] cmp_d;
  logic [NCH-1:0] raw_q;

  assign xfer = wrap && (pend_q || latch_all);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) hold_q[i] <= '0;
    end else if (wr_fire) begin
      hold_q[wr_chan] <= wr_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) act_q[i] <= '0;
      pend_q <= 1'b0;
    end else if (xfer) begin
      for (int i = 0; i < NCH; i++) act_q[i] <= hold_q[i];
      pend_q <= 1'b0;
    end else if (latch_all) begin
      pend_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign cmp_d[g] = wide ? (cnt < act_q[g])
                           : (cnt[NW-1:0] < act_q[g][NW-1:0]);

    // R2: active level only changes at the start of a period
    a_r2_change_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q[g]) |-> (cnt == '0));
    // R5: a zero compared level gives no pulse
    a_r5_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((wide ? (act_q[g] == '0) : (act_q[g][NW-1:0] == '0))) |=> !raw_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= cmp_d;
  end

  assign raw_on = raw_q;

  // R1: an accepted write lands in the addressed holding register
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (hold_q[$past(wr_chan)] == $past(wr_level)));
  // R2: an armed request is consumed at the wrap
  a_r2_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend_q) |=> !pend_q);
endmodule

// File: rtl/gsp_lag_line.sv
module gsp_lag_line #(
  parameter int unsigned LAG = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [LAG-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q[0] <= din;
      for (int j = 1; j < LAG; j++) sh_q[j] <= sh_q[j-1];
    end
  end

  assign dout = en ? sh_q[LAG-1] : din;

  // R6: staggered output repeats the input from LAG cycles back
  a_r6_lag: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (dout == $past(din, LAG)));
  // R6: bypass when staggering is off
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (dout == din));
endmodule

// File: rtl/gsp_pwm_top.sv
module gsp_pwm_top
  import gsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [GS_W-1:0] wr_level,
  input  logic            latch_all,
  input  logic            wide_mode,
  input  logic            stagger_en,
  output logic [NCH-1:0]  ch_on
);
  logic [GS_W-1:0] cnt;
  logic            wrap;
  logic [NCH-1:0]  raw_on;
  logic            wr_fire;

  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;

  gsp_count #(.W(GS_W), .NW(NARROW_W)) u_count (
    .clk(clk), .rst_n(rst_n), .wide(wide_mode), .cnt(cnt), .wrap(wrap)
  );

  gsp_level_bank #(.NCH(NCH), .W(GS_W), .NW(NARROW_W), .CW(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_chan(wr_chan),
    .wr_level(wr_level), .latch_all(latch_all), .wide(wide_mode),
    .cnt(cnt), .wrap(wrap), .raw_on(raw_on)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_out
    if ((g % GRP) == 0) begin : g_lead
      assign ch_on[g] = raw_on[g];
    end else begin : g_lag
      gsp_lag_line #(.LAG(g % GRP)) u_lag (
        .clk(clk), .rst_n(rst_n), .en(stagger_en),
        .din(raw_on[g]), .dout(ch_on[g])
      );
    end
  end

  // R7: outputs are dark right after reset
  a_r7_reset_dark: assert property (@(posedge clk)
    !rst_n |=> (ch_on == '0));
endmodule

// File: tb/tb_gsp_pwm_top.sv
module tb_gsp_pwm_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_chan = '0;
  logic [15:0] wr_level = '0;
  logic        latch_all = 1'b0;
  logic        wide_mode = 1'b0;
  logic        stagger_en = 1'b0;
  logic [15:0] ch_on;

  int checks = 0;
  int fails  = 0;
  bit model_chk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsp_pwm_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_level(wr_level), .latch_all(latch_all),
    .wide_mode(wide_mode), .stagger_en(stagger_en), .ch_on(ch_on)
  );

  // reference model state
  int          m_cnt;
  logic [15:0] m_hold [16];
  logic [15:0] m_act  [16];
  bit          m_pend;
  logic [15:0] m_hist [4];

  function automatic logic [15:0] ideal(int c, bit wide);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = wide ? (c < int'(m_act[i])) : ((c & 4095) < int'(m_act[i] & 16'hFFF));
    return r;
  endfunction

  function automatic logic [15:0] expect_out(bit stag);
    logic [15:0] e;
    for (int i = 0; i < 16; i++) e[i] = stag ? m_hist[i % 4][i] : m_hist[0][i];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0;
      for (int i = 0; i < 16; i++) begin m_hold[i] = 0; m_act[i] = 0; end
      for (int k = 0; k < 4; k++) m_hist[k] = 0;
    end else begin
      bit wrp;
      for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = ideal(m_cnt, wide_mode);
      wrp = wide_mode ? (m_cnt == 65535) : ((m_cnt & 4095) == 4095);
      if (wrp && (m_pend || latch_all)) begin
        for (int i = 0; i < 16; i++) m_act[i] = m_hold[i];
        m_pend = 0;
      end else if (latch_all) m_pend = 1;
      if (wr_valid && wr_ready) m_hold[wr_chan] = wr_level;
      m_cnt = wrp ? 0 : m_cnt + 1;
    end
  end

  // every-cycle comparison against the model (R2, R3, R4, R6, R8)
  always @(negedge clk) begin
    if (model_chk) begin
      logic [15:0] e;
      e = expect_out(stagger_en);
      checks++;
      if (ch_on !== e) begin
        fails++;
        $display("FAIL R8/R6 model cycle: ch_on=%h expected %h", ch_on, e);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(int ch, logic [15:0] v);
    @(posedge clk); #1;
    wr_valid = 1; wr_chan = ch[3:0]; wr_level = v;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic pulse_latch();
    @(posedge clk); #1;
    latch_all = 1;
    @(posedge clk); #1;
    latch_all = 0;
  endtask

  task automatic count_all(int n, output int cnt_o [16]);
    for (int i = 0; i < 16; i++) cnt_o[i] = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < 16; i++) cnt_o[i] += ch_on[i];
    end
  endtask

  logic [15:0] lv [16];
  int          got [16];

  initial begin
    #(CLK_PERIOD * 195000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cycles(4);
    // R7: reset state
    check("R7 outputs in reset", int'(ch_on), 0);
    check("R1 ready low in reset", int'(wr_ready), 0);
    rst_n = 1;
    cycles(1);
    check("R1 ready high after reset", int'(wr_ready), 1);
    model_chk = 1;

    // R1: writes without transfer leave outputs dark
    for (int i = 0; i < 16; i++) begin
      lv[i] = 16'($urandom);
      put(i, lv[i]);
    end
    count_all(4096, got);
    for (int i = 0; i < 4; i++) check("R1 no effect before transfer", got[i], 0);

    // R2/R4: transfer then duty per channel in narrow mode
    pulse_latch();
    cycles(4100);
    count_all(4096, got);
    for (int i = 0; i < 16; i++) check("R4 narrow duty", got[i], int'(lv[i] & 16'hFFF));

    // R5 and extremes; R2 write after request joins the transfer
    lv[0] = 16'h0000; lv[1] = 16'hFFFF; lv[2] = 16'h1000; lv[3] = 16'h0001;
    for (int i = 0; i < 4; i++) put(i, lv[i]);
    pulse_latch();
    lv[5] = 16'h0123;
    put(5, lv[5]);
    stagger_en = 1;
    cycles(4100);
    count_all(4096, got);
    check("R5 zero level dark", got[0], 0);
    check("R4 all-ones low bits", got[1], 4095);
    check("R5 low bits zero in narrow", got[2], 0);
    check("R4 level one", got[3], 1);
    check("R2 late write included", got[5], 'h123);

    // R6: level 1 everywhere, staggered rise positions
    for (int i = 0; i < 16; i++) put(i, 16'h0001);
    pulse_latch();
    cycles(4100);
    while (ch_on[0] !== 1'b1) @(negedge clk);
    for (int d = 0; d < 4; d++) begin
      for (int n = 0; n < 4; n++)
        for (int k = 0; k < 4; k++)
          check("R6 staggered member", int'(ch_on[4*n+k]), int'(k == d));
      @(negedge clk);
    end
    stagger_en = 0;
    cycles(3);
    while (ch_on[0] !== 1'b1) @(negedge clk);
    check("R6 aligned when off", int'(ch_on), 16'hFFFF);

    // R3/R4: wide mode full-width duty
    lv[0] = 16'd5000; lv[1] = 16'hFFFF; lv[2] = 16'h1000; lv[3] = 16'd0;
    for (int i = 4; i < 16; i++) lv[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) put(i, lv[i]);
    pulse_latch();
    cycles(4100);
    wide_mode = 1;
    cycles(2);
    count_all(65536, got);
    for (int i = 0; i < 16; i++) check("R3/R4 wide duty", got[i], int'(lv[i]));

    // R7: reset again clears everything
    rst_n = 0;
    model_chk = 0;
    cycles(2);
    check("R7 reset clears outputs", int'(ch_on), 0);
    rst_n = 1;
    wide_mode = 0;
    cycles(1);
    model_chk = 1;
    count_all(4096, got);
    check("R7 levels cleared", got[1], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule